// File: doc/BRIEF.md
# Serial Bit Stuffing Codec

This block applies the bit-stuffing rule of a CAN-style serial link in both directions. It works one bit at a time, and a single-cycle bit-time strobe advances it. On the send side, raw frame bits come in from an upstream serializer. After a run of equal bits of the configured length, the block emits one bit of the opposite level. For that bit time it raises a hold so the serializer keeps its current bit for the next strobe. On the receive side, sampled bus bits go through a matching run counter. The complementary bit that follows a full run is dropped, so the downstream parser sees only frame content. A bit that extends the run instead raises a one-cycle stuff-error pulse.

Each direction has a region input and a start-of-frame marker, both sampled with every bit. The region input is high from the start bit through the last CRC bit and low over the delimiters, acknowledge and end-of-frame. The start-of-frame marker restarts the run count. Both halves share one parameterised run tracker.

Top module: `bitstuff_codec`

## Requirements
- R1: With the region input high, after RUN_LEN (default 5) consecutive equal bits on `tx_bit_out`, the next strobe emits the complement of that level while `tx_hold` is 1. The upstream bit is presented again on the following strobe.
- R2: An inserted stuff bit counts as the first bit of a new run. After stuffing a 1, four more upstream 1s cause a stuff 0.
- R3: A bit strobed with the region input low and no stuff pending passes through unchanged, `tx_hold` stays 0 and the run count is cleared.
- R4: A strobe with `tx_sof`/`rx_sof` high restarts the run at length 1 with that bit. This happens even when a stuff bit is pending, in which case the start bit is sent or delivered and no stuff bit is produced.
- R5: The region input is sampled per bit. A run that completes on the last in-region bit still gets its stuff bit on the next bit time, even though the region input is then low.
- R6: The receive side delivers every non-stuff bit with `rx_bit_valid` high for one cycle, one clock after its strobe, with the value on `rx_bit_out`. The complementary bit after a full run produces no `rx_bit_valid`.
- R7: On the receive side, a bit equal to the level of a full run raises `rx_stuff_err` for one cycle, one clock after its strobe. That bit is not delivered, and the next bit starts a new run.
- R8: On the receive side, bits with the region input low and no run full are all delivered, however long the run, and no error is raised.
- R9: During and after synchronous reset, `tx_hold`, `rx_bit_valid` and `rx_stuff_err` are 0 and `tx_bit_out` follows `tx_bit_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_stb | input | 1 | One-cycle strobe marking each bit time (both directions) |
| tx_region | input | 1 | Send side: current bit lies in the stuffed region |
| tx_sof | input | 1 | Send side: current bit is the start bit |
| tx_bit_in | input | 1 | Send side: raw bit from the serializer |
| tx_hold | output | 1 | Send side: a stuff bit occupies this bit time, keep the raw bit |
| tx_bit_out | output | 1 | Send side: stuffed bit toward the bus |
| rx_region | input | 1 | Receive side: current bit lies in the stuffed region |
| rx_sof | input | 1 | Receive side: current bit is the start bit |
| rx_bit_in | input | 1 | Receive side: sampled bus bit |
| rx_bit_valid | output | 1 | Receive side: delivered bit is valid this cycle |
| rx_bit_out | output | 1 | Receive side: delivered (destuffed) bit |
| rx_stuff_err | output | 1 | Receive side: run longer than RUN_LEN detected |

## Verification
A start bit can arrive in the very bit time where the run counter is full and a stuff bit is due. Restart and insertion then compete for the same strobe. The bench provokes this with five in-region zeros followed directly by a start bit. It requires the start bit itself on `tx_bit_out` with `tx_hold` low, and requires no stuff bit afterward until a fresh run of five. With the send output looped into the receive side, every raw bit goes into a scoreboard queue. Each bit the receive side delivers is popped and compared, so a stuff bit that is lost or inserted twice shows up as a mismatch.

// File: rtl/bitstuff_pkg.sv
package bitstuff_pkg;

    // Operation applied to a run tracker on a bit strobe.
    typedef enum logic [1:0] {
        RUN_KEEP   = 2'd0,
        RUN_IDLE   = 2'd1,
        RUN_START  = 2'd2,
        RUN_EXTEND = 2'd3
    } run_op_e;

    // One bit time as seen by either half.
    typedef struct packed {
        logic lvl;
        logic sof;
        logic region;
    } serial_bit_t;

    // What a run tracker reports to its owner.
    typedef struct packed {
        logic full;
        logic last;
    } run_view_t;

    function automatic int run_cnt_width(input int run_len);
        return $clog2(run_len + 1);
    endfunction

endpackage

// File: rtl/run_tracker.sv
module run_tracker
    import bitstuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic      clk,
    input  logic      rst,
    input  run_op_e   op,
    input  logic      bit_i,
    output run_view_t view
);
    localparam int CW = run_cnt_width(RUN_LEN);

    logic [CW-1:0] cnt;
    logic          last;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            last <= 1'b1;
        end else begin
            unique case (op)
                RUN_IDLE:  cnt <= '0;
                RUN_START: begin
                    cnt  <= CW'(1);
                    last <= bit_i;
                end
                RUN_EXTEND: begin
                    if (cnt != '0 && bit_i == last && cnt < CW'(RUN_LEN))
                        cnt <= cnt + CW'(1);
                    else
                        cnt <= CW'(1);
                    last <= bit_i;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        view.full = (cnt == CW'(RUN_LEN));
        view.last = last;
    end

    // R1: a run never counts past its limit
    assert_run_bound_R1: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(RUN_LEN));

endmodule

// File: rtl/bitstuff_tx.sv
module bitstuff_tx
    import bitstuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  serial_bit_t up,
    output logic        hold,
    output logic        bit_o
);
    run_view_t view;
    run_op_e   op;

    // A start bit overrides a pending stuff bit.
    always_comb begin
        hold  = view.full & ~up.sof;
        bit_o = hold ? ~view.last : up.lvl;
    end

    always_comb begin
        if (!stb)           op = RUN_KEEP;
        else if (up.sof)    op = RUN_START;
        else if (hold)      op = RUN_START;
        else if (up.region) op = RUN_EXTEND;
        else                op = RUN_IDLE;
    end

    run_tracker #(.RUN_LEN(RUN_LEN)) i_run (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .bit_i(bit_o),
        .view (view)
    );

    // R2: the stuff bit opens a new run, so two stuff bits never follow each other
    assert_single_stuff_R2: assert property (@(posedge clk) disable iff (rst)
        (stb && hold) |=> !hold);

    // R3: an out-of-region bit with nothing pending never leads to a stuff bit
    assert_no_stuff_outside_R3: assert property (@(posedge clk) disable iff (rst)
        (stb && !up.region && !hold) |=> !hold);

endmodule

// File: rtl/bitstuff_rx.sv
module bitstuff_rx
    import bitstuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stb,
    input  serial_bit_t dn,
    output logic        valid,
    output logic        bit_o,
    output logic        err
);
    run_view_t view;
    run_op_e   op;
    logic      is_stuff;
    logic      same_lvl;

    always_comb begin
        is_stuff = view.full & ~dn.sof;
        same_lvl = (dn.lvl == view.last);
    end

    always_comb begin
        if (!stb)           op = RUN_KEEP;
        else if (dn.sof)    op = RUN_START;
        else if (is_stuff)  op = same_lvl ? RUN_IDLE : RUN_START;
        else if (dn.region) op = RUN_EXTEND;
        else                op = RUN_IDLE;
    end

    run_tracker #(.RUN_LEN(RUN_LEN)) i_run (
        .clk  (clk),
        .rst  (rst),
        .op   (op),
        .bit_i(dn.lvl),
        .view (view)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid <= 1'b0;
            bit_o <= 1'b0;
            err   <= 1'b0;
        end else begin
            valid <= stb & ~is_stuff;
            err   <= stb & is_stuff & same_lvl;
            if (stb) bit_o <= dn.lvl;
        end
    end

    // R6: a stuff-position bit is never delivered
    assert_stuff_dropped_R6: assert property (@(posedge clk) disable iff (rst)
        (stb && is_stuff) |=> !valid);

    // R7: error and delivery are exclusive
    assert_err_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(valid && err));

    // R7: an error pulse always follows a strobe
    assert_err_after_stb_R7: assert property (@(posedge clk) disable iff (rst)
        err |-> $past(stb));

endmodule

// File: rtl/bitstuff_codec.sv
module bitstuff_codec
    import bitstuff_pkg::*;
#(
    parameter int RUN_LEN = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic bit_stb,
    input  logic tx_region,
    input  logic tx_sof,
    input  logic tx_bit_in,
    output logic tx_hold,
    output logic tx_bit_out,
    input  logic rx_region,
    input  logic rx_sof,
    input  logic rx_bit_in,
    output logic rx_bit_valid,
    output logic rx_bit_out,
    output logic rx_stuff_err
);
    serial_bit_t tx_up;
    serial_bit_t rx_dn;

    always_comb begin
        tx_up = '{lvl: tx_bit_in, sof: tx_sof, region: tx_region};
        rx_dn = '{lvl: rx_bit_in, sof: rx_sof, region: rx_region};
    end

    bitstuff_tx #(.RUN_LEN(RUN_LEN)) i_tx (
        .clk  (clk),
        .rst  (rst),
        .stb  (bit_stb),
        .up   (tx_up),
        .hold (tx_hold),
        .bit_o(tx_bit_out)
    );

    bitstuff_rx #(.RUN_LEN(RUN_LEN)) i_rx (
        .clk  (clk),
        .rst  (rst),
        .stb  (bit_stb),
        .dn   (rx_dn),
        .valid(rx_bit_valid),
        .bit_o(rx_bit_out),
        .err  (rx_stuff_err)
    );

endmodule

// File: tb/test_bitstuff_codec.sv
module test_bitstuff_codec;
    localparam int RUN = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic bit_stb = 1'b0;
    logic tx_region = 1'b0, tx_sof = 1'b0, tx_bit_in = 1'b1;
    logic loop = 1'b1;
    logic rd_region = 1'b0, rd_sof = 1'b0, rd_bit = 1'b1;
    logic rx_region, rx_sof, rx_bit_in;
    logic tx_hold, tx_bit_out, rx_bit_valid, rx_bit_out, rx_stuff_err;

    int   vectors = 0;
    int   miscompares = 0;
    int   err_seen = 0;
    int   exp_err = 0;
    int   m_cnt = 0;
    logic m_last = 1'b1;
    logic exp_q[$];
    bit   done = 1'b0;

    always #4 clk = ~clk;

    assign rx_bit_in = loop ? tx_bit_out : rd_bit;
    assign rx_region = loop ? tx_region  : rd_region;
    assign rx_sof    = loop ? tx_sof     : rd_sof;

    bitstuff_codec #(.RUN_LEN(RUN)) i_bitstuff_codec (
        .clk(clk), .rst(rst), .bit_stb(bit_stb),
        .tx_region(tx_region), .tx_sof(tx_sof), .tx_bit_in(tx_bit_in),
        .tx_hold(tx_hold), .tx_bit_out(tx_bit_out),
        .rx_region(rx_region), .rx_sof(rx_sof), .rx_bit_in(rx_bit_in),
        .rx_bit_valid(rx_bit_valid), .rx_bit_out(rx_bit_out),
        .rx_stuff_err(rx_stuff_err)
    );

    task automatic cmp(input string tag, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each delivered bit.
    always @(negedge clk) begin
        if (!rst) begin
            if (rx_bit_valid) begin
                if (exp_q.size() == 0) begin
                    cmp("R6", "unexpected rx bit (queue size)", 1, 0);
                end else begin
                    logic e;
                    e = exp_q.pop_front();
                    cmp("R6", "rx_bit_out", int'(rx_bit_out), int'(e));
                end
            end
            if (rx_stuff_err) err_seen++;
        end
    end

    // Send one raw bit, retrying while the block inserts stuff bits.
    task automatic tx_push(input logic b, input logic reg_en, input logic sof, input string tag);
        bit accepted;
        accepted = 1'b0;
        while (!accepted) begin
            logic e_out, e_hold;
            if (sof) begin
                e_hold = 1'b0; e_out = b; m_cnt = 1; m_last = b;
            end else if (m_cnt == RUN) begin
                e_hold = 1'b1; e_out = ~m_last; m_last = ~m_last; m_cnt = 1;
            end else if (reg_en) begin
                e_hold = 1'b0; e_out = b;
                m_cnt = (m_cnt != 0 && b == m_last) ? m_cnt + 1 : 1;
                m_last = b;
            end else begin
                e_hold = 1'b0; e_out = b; m_cnt = 0;
            end
            @(negedge clk);
            loop = 1'b1;
            tx_bit_in = b; tx_region = reg_en; tx_sof = sof; bit_stb = 1'b1;
            #1;
            cmp(tag, "tx_bit_out", int'(tx_bit_out), int'(e_out));
            cmp(tag, "tx_hold", int'(tx_hold), int'(e_hold));
            if (!e_hold) begin
                exp_q.push_back(b);
                accepted = 1'b1;
            end
            @(negedge clk);
            bit_stb = 1'b0; tx_sof = 1'b0;
            repeat (2) @(negedge clk);
        end
    endtask

    // Drive the receive side directly with a known outcome.
    task automatic rx_push(input logic b, input logic reg_en, input logic sof,
                           input bit deliver, input bit err);
        @(negedge clk);
        loop = 1'b0;
        tx_region = 1'b0; tx_sof = 1'b0;
        rd_bit = b; rd_region = reg_en; rd_sof = sof; bit_stb = 1'b1;
        if (deliver) exp_q.push_back(b);
        if (err) exp_err++;
        @(negedge clk);
        bit_stb = 1'b0; rd_sof = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic prev;
        repeat (4) @(negedge clk);
        // R9: reset state
        #1;
        cmp("R9", "tx_hold in reset", int'(tx_hold), 0);
        cmp("R9", "rx_bit_valid in reset", int'(rx_bit_valid), 0);
        cmp("R9", "rx_stuff_err in reset", int'(rx_stuff_err), 0);
        @(negedge clk) rst = 1'b0;
        #1;
        cmp("R9", "tx_hold after reset", int'(tx_hold), 0);
        cmp("R9", "tx_bit_out follows input", int'(tx_bit_out), 1);

        // R1 and R2: 5 zeros then stuff 1, then the stuff bit opens a run of ones
        tx_push(1'b0, 1'b1, 1'b1, "R4");
        repeat (4) tx_push(1'b0, 1'b1, 1'b0, "R1");
        repeat (4) tx_push(1'b1, 1'b1, 1'b0, "R2");
        tx_push(1'b0, 1'b1, 1'b0, "R2");
        tx_push(1'b1, 1'b1, 1'b0, "R1");

        // R5: run completes on last in-region bit; R3: region low passes bits
        tx_push(1'b0, 1'b1, 1'b1, "R4");
        repeat (5) tx_push(1'b1, 1'b1, 1'b0, "R5");
        tx_push(1'b1, 1'b0, 1'b0, "R5");
        repeat (7) tx_push(1'b1, 1'b0, 1'b0, "R3");

        // R4: start bit in the same bit time as a pending stuff bit
        tx_push(1'b0, 1'b1, 1'b1, "R4");
        repeat (4) tx_push(1'b0, 1'b1, 1'b0, "R4");
        tx_push(1'b0, 1'b1, 1'b1, "R4");
        repeat (3) tx_push(1'b0, 1'b1, 1'b0, "R4");
        tx_push(1'b1, 1'b1, 1'b0, "R4");
        repeat (3) tx_push(1'b1, 1'b0, 1'b0, "R3");

        // R1: frames with long runs, looped through the receive side
        for (int f = 0; f < 3; f++) begin
            tx_push(1'b0, 1'b1, 1'b1, "R4");
            prev = 1'b0;
            for (int i = 0; i < 50; i++) begin
                if ($urandom % 4 == 0) prev = ~prev;
                tx_push(prev, 1'b1, 1'b0, "R1");
            end
            repeat (10) tx_push(1'b1, 1'b0, 1'b0, "R8");
        end
        repeat (4) @(negedge clk);
        cmp("R6", "loopback queue left", exp_q.size(), 0);
        cmp("R8", "loopback stuff errors", err_seen, exp_err);

        // R6 and R7: direct receive stream
        rx_push(1'b0, 1'b1, 1'b1, 1, 0);
        repeat (4) rx_push(1'b0, 1'b1, 1'b0, 1, 0);
        rx_push(1'b1, 1'b1, 1'b0, 0, 0);          // R6 stuff bit dropped
        repeat (4) rx_push(1'b1, 1'b1, 1'b0, 1, 0);
        rx_push(1'b1, 1'b1, 1'b0, 0, 1);          // R7 sixth equal bit
        repeat (5) rx_push(1'b0, 1'b1, 1'b0, 1, 0); // R7 new run after error
        rx_push(1'b1, 1'b1, 1'b0, 0, 0);          // R6 stuff bit dropped
        repeat (7) rx_push(1'b0, 1'b0, 1'b0, 1, 0); // R8 long run outside region
        repeat (4) @(negedge clk);
        cmp("R7", "stuff error count", err_seen, exp_err);
        cmp("R6", "direct queue left", exp_q.size(), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule